// File: doc/BRIEF.md
# Three-Segment Hybrid Final Adder

A combinational adder for the last carry-propagate step of a parallel multiplier, where the low result bits arrive early and the high bits arrive late. The operand width is split into three contiguous bit ranges. The lowest range is a ripple-carry chain. The middle range is a Brent-Kung parallel-prefix tree. The top range is a carry-select stage that precomputes both outcomes and picks one with the carry that leaves the prefix range.

Each range width is an elaboration-time parameter. If only the total width and the ripple width are given, the prefix width defaults to the largest power of two that fits in the remaining bits, and the select range takes whatever is left. A range of width zero is left out, and the carry passes straight through it. A partition that is negative or does not cover the total width stops elaboration.

Top module: `hyb_final_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals `a_i + b_i + cin_i` as an unsigned (N+1)-bit value, for every input, with the default partition N=32, ripple 7, prefix 16, select 9.
- R2: The ripple range covers bits [W_RPL-1:0] and takes `cin_i`. Its carry-out equals bit W_RPL of `a_i[W_RPL-1:0] + b_i[W_RPL-1:0] + cin_i`.
- R3: The prefix range covers the next W_BK bits. It takes the ripple carry as its position-zero generate term, and its carry-out equals bit W_RPL+W_BK of the masked low-part sum.
- R4: The select range covers the top W_CS bits. Its sum bits and `cout_o` equal `a_hi + b_hi + c`, where c is the prefix-range carry-out.
- R5: The default prefix width is the largest power of two not above N-W_RPL, and the select width is the remainder. N=32 with W_RPL=7 gives 16 and 9, and N=16 with W_RPL=0 gives 16 and 0.
- R6: A partition with a zero-width range still gives the exact sum and carry (checked with 16/0/16/0 and 10/3/0/7). Partition 24/5/8/11 is exact as well.
- R7: A carry that starts at `cin_i` travels the full width: all-ones plus zero with `cin_i`=1 gives a sum of zero and `cout_o`=1. A carry that starts just below any range boundary crosses that boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| cout_o | output | 1 | Carry out of bit N-1 |

## Verification
The checks in the checker module assume that the operand and carry inputs are settled, two-state values when they are evaluated. They also assume that the elaboration guard has already rejected any partition that does not cover N. The bench changes every input on the falling clock edge and compares on the rising edge, so each comparison sees a settled combinational result. It drives only defined values: random words masked to each instance's width, all-zeros, all-ones, and ramps of low ones that push a carry across every bit position, including each range boundary.

// File: rtl/hyb_add_pkg.sv
package hyb_add_pkg;
  // largest power of two not above n - wrpl, zero when nothing is left
  function automatic int bk_width_default(int n, int wrpl);
    int rem;
    int w;
    rem = n - wrpl;
    if (rem <= 0) return 0;
    w = 1;
    while (w * 2 <= rem) w = w * 2;
    return w;
  endfunction
endpackage

// File: rtl/hyb_rpl_seg.sv
module hyb_rpl_seg #(
  parameter int W = 7
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W:0] c;
  assign c[0] = ci_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s_o[i]   = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end
  assign co_o = c[W];
endmodule

// File: rtl/hyb_bk_seg.sv
module hyb_bk_seg #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  // position 0 carries ci_i as a pure generate term
  localparam int L  = W + 1;
  localparam int LG = $clog2(L);
  localparam int NS = 2 * LG;
  localparam int FS = NS - 1;

  logic [NS*L-1:0] g_q;
  logic [NS*L-1:0] p_q;
  logic [W-1:0]    p_bit;

  assign p_bit      = a_i ^ b_i;
  assign g_q[0]     = ci_i;
  assign p_q[0]     = 1'b0;
  assign g_q[L-1:1] = a_i & b_i;
  assign p_q[L-1:1] = p_bit;

  // up-sweep
  for (genvar lv = 0; lv < LG; lv++) begin : g_up
    localparam int S = lv + 1;
    for (genvar i = 0; i < L; i++) begin : g_pos
      if (((i + 1) % (1 << (lv + 1))) == 0) begin : g_op
        assign g_q[S*L+i] = g_q[(S-1)*L+i] | (p_q[(S-1)*L+i] & g_q[(S-1)*L+i-(1<<lv)]);
        assign p_q[S*L+i] = p_q[(S-1)*L+i] & p_q[(S-1)*L+i-(1<<lv)];
      end else begin : g_pass
        assign g_q[S*L+i] = g_q[(S-1)*L+i];
        assign p_q[S*L+i] = p_q[(S-1)*L+i];
      end
    end
  end

  // down-sweep fills the remaining positions
  for (genvar dv = 0; dv < LG - 1; dv++) begin : g_dn
    localparam int LV = LG - 2 - dv;
    localparam int S  = LG + 1 + dv;
    for (genvar i = 0; i < L; i++) begin : g_pos
      if ((((i + 1) % (1 << (LV + 1))) == (1 << LV)) && (i >= (1 << (LV + 1)))) begin : g_op
        assign g_q[S*L+i] = g_q[(S-1)*L+i] | (p_q[(S-1)*L+i] & g_q[(S-1)*L+i-(1<<LV)]);
        assign p_q[S*L+i] = p_q[(S-1)*L+i] & p_q[(S-1)*L+i-(1<<LV)];
      end else begin : g_pass
        assign g_q[S*L+i] = g_q[(S-1)*L+i];
        assign p_q[S*L+i] = p_q[(S-1)*L+i];
      end
    end
  end

  for (genvar j = 0; j < W; j++) begin : g_sum
    assign s_o[j] = p_bit[j] ^ g_q[FS*L+j];
  end
  assign co_o = g_q[FS*L+W];
endmodule

// File: rtl/hyb_cs_seg.sv
module hyb_cs_seg #(
  parameter int W = 9
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W:0] cand0;
  logic [W:0] cand1;
  assign cand0 = {1'b0, a_i} + {1'b0, b_i};
  assign cand1 = {1'b0, a_i} + {1'b0, b_i} + (W+1)'(1);
  assign {co_o, s_o} = sel_i ? cand1 : cand0;
endmodule

// File: rtl/hyb_final_adder.sv
module hyb_final_adder #(
  parameter int N     = 32,
  parameter int W_RPL = 7,
  parameter int W_BK  = hyb_add_pkg::bk_width_default(N, W_RPL),
  parameter int W_CS  = N - W_RPL - W_BK
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  localparam int LO_BK = W_RPL;
  localparam int LO_CS = W_RPL + W_BK;

  if (W_RPL < 0 || W_BK < 0 || W_CS < 0 || (W_RPL + W_BK + W_CS) != N) begin : g_bad_cfg
    $fatal(1, "hyb_final_adder: segment widths do not partition N");
  end

  logic c_rpl;
  logic c_bk;

  if (W_RPL > 0) begin : g_rpl
    hyb_rpl_seg #(.W(W_RPL)) u_rpl (
      .a_i (a_i[W_RPL-1:0]),
      .b_i (b_i[W_RPL-1:0]),
      .ci_i(cin_i),
      .s_o (sum_o[W_RPL-1:0]),
      .co_o(c_rpl)
    );
  end else begin : g_no_rpl
    assign c_rpl = cin_i;
  end

  if (W_BK > 0) begin : g_bk
    hyb_bk_seg #(.W(W_BK)) u_bk (
      .a_i (a_i[LO_BK +: W_BK]),
      .b_i (b_i[LO_BK +: W_BK]),
      .ci_i(c_rpl),
      .s_o (sum_o[LO_BK +: W_BK]),
      .co_o(c_bk)
    );
  end else begin : g_no_bk
    assign c_bk = c_rpl;
  end

  if (W_CS > 0) begin : g_cs
    hyb_cs_seg #(.W(W_CS)) u_cs (
      .a_i  (a_i[LO_CS +: W_CS]),
      .b_i  (b_i[LO_CS +: W_CS]),
      .sel_i(c_bk),
      .s_o  (sum_o[LO_CS +: W_CS]),
      .co_o (cout_o)
    );
  end else begin : g_no_cs
    assign cout_o = c_bk;
  end
endmodule

// File: rtl/hyb_add_chk.sv
module hyb_add_chk #(
  parameter int N     = 32,
  parameter int W_RPL = 7,
  parameter int W_BK  = 16
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         cin_i,
  input logic [N-1:0] sum_i,
  input logic         cout_i,
  input logic         c_rpl_i,
  input logic         c_bk_i
);
  localparam int LO_CS = W_RPL + W_BK;

  function automatic logic [N:0] low_mask(int w);
    return ((N+1)'(1) << w) - (N+1)'(1);
  endfunction

  logic [N:0] ax, bx, lo_rpl, lo_bk, hi_exp, hi_got;
  always_comb begin
    ax     = {1'b0, a_i};
    bx     = {1'b0, b_i};
    lo_rpl = (ax & low_mask(W_RPL)) + (bx & low_mask(W_RPL)) + (N+1)'(cin_i);
    lo_bk  = (ax & low_mask(LO_CS)) + (bx & low_mask(LO_CS)) + (N+1)'(cin_i);
    hi_exp = (ax >> LO_CS) + (bx >> LO_CS) + (N+1)'(c_bk_i);
    hi_got = {cout_i, sum_i} >> LO_CS;

    // R1
    total_sum_chk: assert ({cout_i, sum_i} == ax + bx + (N+1)'(cin_i));
    // R2
    rpl_carry_chk: assert (c_rpl_i == lo_rpl[W_RPL]);
    // R3
    bk_carry_chk: assert (c_bk_i == lo_bk[LO_CS]);
    // R4
    cs_select_chk: assert (hi_got == hi_exp);
  end
endmodule

bind hyb_final_adder hyb_add_chk #(.N(N), .W_RPL(W_RPL), .W_BK(W_BK)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_i  (sum_o),
  .cout_i (cout_o),
  .c_rpl_i(c_rpl),
  .c_bk_i (c_bk)
);

// File: tb/tb_hyb_final_adder.sv
module tb_hyb_final_adder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] a0, b0, s0; logic c0, co0;
  logic [15:0] a1, b1, s1; logic c1, co1;
  logic [23:0] a2, b2, s2; logic c2, co2;
  logic [9:0]  a3, b3, s3; logic c3, co3;

  hyb_final_adder dut (.a_i(a0), .b_i(b0), .cin_i(c0), .sum_o(s0), .cout_o(co0));
  hyb_final_adder #(.N(16), .W_RPL(0)) dut_p16 (.a_i(a1), .b_i(b1), .cin_i(c1), .sum_o(s1), .cout_o(co1));
  hyb_final_adder #(.N(24), .W_RPL(5), .W_BK(8), .W_CS(11)) dut_p24 (.a_i(a2), .b_i(b2), .cin_i(c2), .sum_o(s2), .cout_o(co2));
  hyb_final_adder #(.N(10), .W_RPL(3), .W_BK(0), .W_CS(7)) dut_p10 (.a_i(a3), .b_i(b3), .cin_i(c3), .sum_o(s3), .cout_o(co3));

  task automatic check(string tag, int n, longint unsigned a, longint unsigned b, bit ci,
                       longint unsigned got);
    longint unsigned m, exp;
    m   = (64'd1 << n) - 1;
    exp = (a & m) + (b & m) + ci;
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s n=%0d a=%h b=%h ci=%0d actual=%h expected=%h", tag, n, a, b, ci, got, exp);
    end
  endtask

  task automatic apply(string tag, longint unsigned a, longint unsigned b, bit ci);
    @(negedge clk);
    a0 = a[31:0]; b0 = b[31:0]; c0 = ci;
    a1 = a[15:0]; b1 = b[15:0]; c1 = ci;
    a2 = a[23:0]; b2 = b[23:0]; c2 = ci;
    a3 = a[9:0];  b3 = b[9:0];  c3 = ci;
    @(posedge clk); #1;
    check({tag, " R1 32/7/16/9"}, 32, a, b, ci, {31'd0, co0, s0});
    check({tag, " R6 16/0/16/0"}, 16, a, b, ci, {47'd0, co1, s1});
    check({tag, " R6 24/5/8/11"}, 24, a, b, ci, {39'd0, co2, s2});
    check({tag, " R6 10/3/0/7"},  10, a, b, ci, {53'd0, co3, s3});
  endtask

  task automatic check_int(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  initial begin
    a0 = '0; b0 = '0; c0 = 1'b0; a1 = '0; b1 = '0; c1 = 1'b0;
    a2 = '0; b2 = '0; c2 = 1'b0; a3 = '0; b3 = '0; c3 = 1'b0;
    // R5 default partition
    check_int("R5 bk 32/7", hyb_add_pkg::bk_width_default(32, 7), 16);
    check_int("R5 bk 16/0", hyb_add_pkg::bk_width_default(16, 0), 16);
    check_int("R5 bk 20/3", hyb_add_pkg::bk_width_default(20, 3), 16);
    check_int("R5 cs 32/7", 32 - 7 - hyb_add_pkg::bk_width_default(32, 7), 9);
    apply("zeros", 0, 0, 1'b0);
    // R7 full-width carry
    apply("R7 ones+cin", 64'hFFFF_FFFF, 0, 1'b1);
    apply("R7 ones+ones", 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b1);
    apply("R7 ones nocin", 64'hFFFF_FFFF, 0, 1'b0);
    // R2 R3 R4 R7 carry from below each bit position, covers every boundary
    for (int k = 0; k <= 32; k++) begin
      apply("R7 ramp cin", (64'd1 << k) - 1, 0, 1'b1);
      apply("R3 ramp b1", (64'd1 << k) - 1, 1, 1'b0);
      apply("R4 split", (64'd1 << k) - 1, 64'hFFFF_FFFF ^ ((64'd1 << k) - 1), 1'b1);
    end
    for (int r = 0; r < 2000; r++) begin
      apply("R1 random", {32'd0, $urandom}, {32'd0, $urandom}, 1'($urandom));
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule